// File: doc/BRIEF.md
# Serial Bit-Clock Generator and Selector

This block makes the bit-rate timing for a serial port that runs either in one synchronous mode or in an asynchronous mode. All of its logic runs on the core clock. It produces two single-cycle strobes, `tx_bit_en` and `rx_bit_en`, that tell the shifters when to move one bit. It also produces a drive value and an output enable for a bidirectional serial clock pin.

The block has two timing sources. The internal source is a programmable down-counter on the core clock. The external source is the serial clock pin, which is resynchronised to the core clock and reduced to edge pulses. In synchronous mode both directions share one source: the internal counter when the port is master, the pin when it is slave. The internal clock is gated by a transfer-active input, and its half period never drops below a fixed fraction of the core clock. In asynchronous mode each direction picks its own source. Each direction divides its sixteen-times-rate enable down to one strobe per bit, and the receive divider is realigned whenever a start bit is seen.

When the port drives the pin in asynchronous mode, the pin carries either the 1x bit clock or the 16x clock. In that mode the pin clock runs continuously.

Top module: `serclk_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `tx_bit_en`, `rx_bit_en` and `sclk_out` are 0.
- R2: With `sync_mode`=1 and `is_master`=1, the internal counter ticks once every max(`rate_div`,7)+1 core cycles. While `xfer_act`=1, `sclk_out` toggles on each tick, so there are two ticks per bit. `tx_bit_en` and `rx_bit_en` pulse together, for one cycle, after each high-to-low transition of `sclk_out`.
- R3: In synchronous master mode, `sclk_out` never holds a level for fewer than 8 core cycles, even when `rate_div` is below 7.
- R4: In synchronous master mode with `xfer_act`=0, `sclk_out` is 0 and neither strobe fires from the next cycle on.
- R5: With `sync_mode`=1 and `is_master`=0, each falling edge on `sclk_in` gives one pulse on both strobes, three core cycles after the falling edge is first sampled.
- R6: With `sync_mode`=0, a direction whose select (`tx_ext` or `rx_ext`) is 0 counts internal ticks (one every `rate_div`+1 cycles). A direction whose select is 1 counts rising edges of the synchronised `sclk_in`. Each direction's strobe fires once every 16 counted events.
- R7: In asynchronous mode the two directions are independent: every combination of `tx_ext` and `rx_ext` is allowed.
- R8: In asynchronous mode, `rx_start`=1 suppresses `rx_bit_en` in the next cycle and restarts the receive divider at its midpoint. The next `rx_bit_en` comes after exactly 8 further receive events.
- R9: In asynchronous mode with the pin driven, `pin_x16`=1 puts the 16x clock on `sclk_out`: high while the internal counter is above half its reload value. `pin_x16`=0 puts the 1x clock there: the most significant bit of the transmit divider, high for 8 events and low for 8 events.
- R10: `sclk_oe` is 1 in synchronous master mode and in asynchronous mode with both selects 0; in every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| is_master | input | 1 | synchronous mode: 1 = internal clock drives the pin |
| xfer_act | input | 1 | synchronous master: 1 lets the clock run |
| tx_ext | input | 1 | asynchronous transmit source: 1 = pin, 0 = internal |
| rx_ext | input | 1 | asynchronous receive source: 1 = pin, 0 = internal |
| pin_x16 | input | 1 | driven pin rate: 1 = 16x, 0 = 1x |
| rate_div | input | 12 | internal tick period minus one, in core cycles |
| rx_start | input | 1 | pulse on a detected receive start bit |
| sclk_in | input | 1 | serial clock pin input (asynchronous to clk) |
| tx_bit_en | output | 1 | one-cycle transmit bit strobe |
| rx_bit_en | output | 1 | one-cycle receive bit strobe |
| sclk_out | output | 1 | serial clock pin drive value |
| sclk_oe | output | 1 | serial clock pin output enable |

## Verification
The block is driven through all four source arrangements: internal master, external slave, and asynchronous with the transmit and receive sources split both ways. A synchronised pin clock with a different period is used each time, so a strobe taken from the wrong source lands on the wrong cycle. Synchronous runs use one divider value below the floor and one above it, which separates a missing floor from a wrong reload. A timed start pulse checks that the receive divider realigns to its midpoint. The two pin-rate settings are compared through the measured high time of `sclk_out`.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    // registered outputs of the top level
    typedef struct packed {
        logic tog;    // synchronous half-bit toggle
        logic tx_en;  // transmit bit strobe
        logic rx_en;  // receive bit strobe
        logic pin;    // serial clock pin drive
    } top_state_t;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;

endpackage

// File: rtl/serclk_sync.sv
module serclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    localparam int LEN = STAGES + 1;

    typedef struct packed {
        logic [LEN-1:0] chain;
    } sync_state_t;

    sync_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[LEN-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // last synchroniser stage against one further history flop
    assign rise = st_q.chain[LEN-2] & ~st_q.chain[LEN-1];
    assign fall = ~st_q.chain[LEN-2] & st_q.chain[LEN-1];
endmodule

// File: rtl/serclk_rate.sv
module serclk_rate #(
    parameter int DIV_W      = 12,
    parameter int MIN_RELOAD = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             floor_en,
    output logic             tick,
    output logic             hi_half
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_RELOAD);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } rate_state_t;

    rate_state_t      st_q, st_d;
    logic [DIV_W-1:0] reload;

    always_comb begin
        reload = rate_div;
        if (floor_en && rate_div < FLOOR) reload = FLOOR;
        st_d = st_q;
        if (st_q.cnt == '0) st_d.cnt = reload;
        else                st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick    = (st_q.cnt == '0);
    assign hi_half = (st_q.cnt > (reload >> 1));
endmodule

// File: rtl/serclk_ovs.sv
module serclk_ovs #(
    parameter int RATIO = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     load,
    input  logic [$clog2(RATIO)-1:0] load_val,
    output logic                     wrap,
    output logic                     msb
);
    localparam int                W    = $clog2(RATIO);
    localparam logic [W-1:0]      LAST = W'(RATIO - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ovs_state_t;

    ovs_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (en) begin
            if (st_q.cnt == LAST) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap = en & ~load & (st_q.cnt == LAST);
    assign msb  = st_q.cnt[W-1];
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int OVS         = 16,
    parameter int SYNC_RATIO  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic             is_master,
    input  logic             xfer_act,
    input  logic             tx_ext,
    input  logic             rx_ext,
    input  logic             pin_x16,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             rx_start,
    input  logic             sclk_in,
    output logic             tx_bit_en,
    output logic             rx_bit_en,
    output logic             sclk_out,
    output logic             sclk_oe
);
    localparam int            OVS_W      = $clog2(OVS);
    localparam int            MIN_RELOAD = SYNC_RATIO - 1;
    localparam logic [OVS_W-1:0] MID     = OVS_W'(OVS / 2);

    top_state_t st_q, st_d;

    logic       ext_rise, ext_fall;
    logic       tick, hi_half;
    logic [1:0] dir_ext, dir_en, dir_load, dir_wrap, dir_msb;
    logic       sync_strobe;

    serclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    serclk_rate #(.DIV_W(DIV_W), .MIN_RELOAD(MIN_RELOAD)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_div (rate_div),
        .floor_en (sync_mode),
        .tick     (tick),
        .hi_half  (hi_half)
    );

    assign dir_ext = {rx_ext, tx_ext};

    for (genvar g = 0; g < 2; g++) begin : g_dir
        always_comb begin
            dir_en[g]   = ~sync_mode & (dir_ext[g] ? ext_rise : tick);
            dir_load[g] = sync_mode | ((g == DIR_RX) & rx_start);
        end
        serclk_ovs #(.RATIO(OVS)) u_ovs (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (dir_en[g]),
            .load     (dir_load[g]),
            .load_val (sync_mode ? '0 : MID),
            .wrap     (dir_wrap[g]),
            .msb      (dir_msb[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        sync_strobe = is_master ? (xfer_act & tick & st_q.tog) : ext_fall;
        if (sync_mode) begin
            if (!is_master || !xfer_act) st_d.tog = 1'b0;
            else if (tick)               st_d.tog = ~st_q.tog;
            st_d.tx_en = sync_strobe;
            st_d.rx_en = sync_strobe;
            st_d.pin   = st_d.tog;
        end else begin
            st_d.tog   = 1'b0;
            st_d.tx_en = dir_wrap[DIR_TX];
            st_d.rx_en = dir_wrap[DIR_RX];
            st_d.pin   = pin_x16 ? hi_half : dir_msb[DIR_TX];
        end
        sclk_oe = sync_mode ? is_master : ~(tx_ext | rx_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_bit_en = st_q.tx_en;
    assign rx_bit_en = st_q.rx_en;
    assign sclk_out  = st_q.pin;
endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_mode,
    input logic is_master,
    input logic xfer_act,
    input logic rx_start,
    input logic tx_bit_en,
    input logic rx_bit_en,
    input logic sclk_out
);
    // R2: both strobes move together while synchronous
    assert_sync_lockstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $past(sync_mode)) |-> (tx_bit_en == rx_bit_en));

    // R4: a stopped master clock stays low and quiet
    assert_gated_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && is_master && !xfer_act) |=> (!tx_bit_en && !sclk_out));

    // R6: an asynchronous receive strobe is never two cycles long
    assert_no_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_en && !sync_mode && $past(!sync_mode)) |=> !rx_bit_en);

    // R8: a start detection cancels the next receive strobe
    assert_start_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && rx_start) |=> !rx_bit_en);
endmodule

bind serclk_gen serclk_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .is_master (is_master),
    .xfer_act  (xfer_act),
    .rx_start  (rx_start),
    .tx_bit_en (tx_bit_en),
    .rx_bit_en (rx_bit_en),
    .sclk_out  (sclk_out)
);

// File: tb/test_serclk_gen.sv
`timescale 1ns/1ps
module test_serclk_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        sync_mode = 0, is_master = 1, xfer_act = 0;
    logic        tx_ext = 0, rx_ext = 0, pin_x16 = 0, rx_start = 0;
    logic [11:0] rate_div = 0;
    logic        sclk_in = 0;
    logic        tx_bit_en, rx_bit_en, sclk_out, sclk_oe;

    int errors = 0, checks = 0;
    bit ext_on = 0;
    int ext_half = 5, ext_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serclk_gen i_serclk_gen (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .is_master(is_master),
        .xfer_act(xfer_act), .tx_ext(tx_ext), .rx_ext(rx_ext), .pin_x16(pin_x16),
        .rate_div(rate_div), .rx_start(rx_start), .sclk_in(sclk_in),
        .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // external pin clock source
    always @(negedge clk) begin
        if (ext_on) begin
            ext_cnt++;
            if (ext_cnt >= ext_half) begin
                sclk_in <= ~sclk_in;
                ext_cnt = 0;
            end
        end
    end

    // behavioural reference, updated on each edge and compared late in the cycle
    int m_s1, m_s2, m_s3, m_cnt, m_tog, m_tx16, m_rx16, m_txen, m_rxen, m_pin;
    initial begin
        m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_tog = 0;
        m_tx16 = 0; m_rx16 = 0; m_txen = 0; m_rxen = 0; m_pin = 0;
    end

    function automatic string mode_tag();
        if (sync_mode) return is_master ? "R2" : "R5";
        if (tx_ext != rx_ext) return "R7";
        return "R6";
    endfunction

    always @(posedge clk) begin
        int rel, ncnt, ntog, ntx16, nrx16, ntxen, nrxen, npin;
        bit tick, er, ef, e0, e1;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_tog = 0;
            m_tx16 = 0; m_rx16 = 0; m_txen = 0; m_rxen = 0; m_pin = 0;
        end else begin
            er   = (m_s2 == 1) && (m_s3 == 0);
            ef   = (m_s2 == 0) && (m_s3 == 1);
            rel  = (sync_mode && rate_div < 7) ? 7 : int'(rate_div);
            tick = (m_cnt == 0);
            ncnt = tick ? rel : m_cnt - 1;
            if (sync_mode) begin
                if (is_master && xfer_act) ntog = tick ? 1 - m_tog : m_tog;
                else ntog = 0;
                ntxen = is_master ? int'(xfer_act && tick && m_tog == 1) : int'(ef);
                nrxen = ntxen;
                ntx16 = 0; nrx16 = 0;
                npin  = ntog;
            end else begin
                ntog  = 0;
                e0    = tx_ext ? er : tick;
                e1    = rx_ext ? er : tick;
                ntxen = int'(e0 && m_tx16 == 15);
                ntx16 = e0 ? (m_tx16 + 1) % 16 : m_tx16;
                if (rx_start) begin
                    nrx16 = 8; nrxen = 0;
                end else begin
                    nrxen = int'(e1 && m_rx16 == 15);
                    nrx16 = e1 ? (m_rx16 + 1) % 16 : m_rx16;
                end
                npin = pin_x16 ? int'(m_cnt > rel / 2) : int'(m_tx16 >= 8);
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(sclk_in);
            m_cnt = ncnt; m_tog = ntog; m_tx16 = ntx16; m_rx16 = nrx16;
            m_txen = ntxen; m_rxen = nrxen; m_pin = npin;
            #3;
            if (!done) begin
                check(mode_tag(), "tx_bit_en", int'(tx_bit_en), m_txen);
                check(mode_tag(), "rx_bit_en", int'(rx_bit_en), m_rxen);
                check(sync_mode ? mode_tag() : "R9", "sclk_out", int'(sclk_out), m_pin);
                check("R10", "sclk_oe", int'(sclk_oe),
                      sync_mode ? int'(is_master) : int'(!(tx_ext || rx_ext)));
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycles spent at a level of sclk_out, starting at its next rise (lvl=1) or fall (lvl=0)
    task automatic level_len(input bit lvl, output int n);
        int guard = 0;
        n = 0;
        while (sclk_out == lvl && guard < 3000) begin @(posedge clk); #1; guard++; end
        while (sclk_out != lvl && guard < 3000) begin @(posedge clk); #1; guard++; end
        while (sclk_out == lvl && guard < 3000) begin @(posedge clk); #1; guard++; n++; end
    endtask

    initial begin
        int n;
        run(3);
        check("R1", "tx_bit_en in reset", int'(tx_bit_en), 0);
        check("R1", "sclk_out in reset", int'(sclk_out), 0);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1;
        check("R1", "rx_bit_en after reset", int'(rx_bit_en), 0);

        // synchronous master, divider below floor then above
        @(negedge clk); sync_mode = 1; is_master = 1; xfer_act = 1; rate_div = 2;
        run(120);
        level_len(1, n); check("R3", "high time with floor", n, 8);
        @(negedge clk); rate_div = 10;
        run(60);
        level_len(0, n); check("R2", "low time rate_div=10", n, 11);
        @(negedge clk); xfer_act = 0;
        run(60);
        check("R4", "pin parked", int'(sclk_out), 0);
        @(negedge clk); xfer_act = 1;
        run(100);

        // synchronous slave
        @(negedge clk); is_master = 0; ext_half = 5; ext_on = 1;
        run(200);
        @(negedge clk); ext_half = 7;
        run(150);

        // asynchronous, internal both ways, pin rate choices
        @(negedge clk); sync_mode = 0; rate_div = 3; pin_x16 = 1;
        run(100);
        level_len(1, n); check("R9", "16x pin high time", n, 2);
        @(negedge clk); pin_x16 = 0;
        run(200);
        level_len(1, n); check("R9", "1x pin high time", n, 32);

        // asynchronous split sources
        @(negedge clk); tx_ext = 1; rx_ext = 0; ext_half = 3; rate_div = 1;
        run(300);
        @(negedge clk); tx_ext = 0; rx_ext = 1;
        run(300);
        @(negedge clk); tx_ext = 1; rx_ext = 1; ext_half = 2;
        run(200);

        // receive realignment on start detection
        @(negedge clk); tx_ext = 0; rx_ext = 0; rate_div = 0;
        run(37);
        @(negedge clk); rx_start = 1;
        @(posedge clk); #1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk) rx_start = 0;
            @(posedge clk); #1;
            n++;
            if (rx_bit_en) break;
        end
        check("R8", "cycles from start to rx strobe", n, 8);
        run(5);
        @(negedge clk); rx_start = 1;
        @(negedge clk); rx_start = 0;
        run(100);

        done = 1;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule